// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

This block is a single up-counting timer/counter channel held in two byte registers. It advances either on an internal machine-cycle strobe, produced by dividing the system clock by a fixed ratio, or on falling transitions of an external pin that is sampled once per machine cycle. A run control enables counting. An optional gate qualifier also requires an external level to be high before counting is allowed.

A two-bit mode selector picks how the two bytes combine. The modes are a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself from the upper byte, and a frozen state. On every overflow a sticky flag is set. The flag can drive an interrupt request and stays set until it is acknowledged. Each byte can be preset through a simple write strobe.

Top module: `mmtc_channel`

## Requirements
- R1: After reset both count bytes read 0x00, and the overflow flag and the interrupt request are low.
- R2: In timer mode (ext_sel = 0) the count advances by exactly one per machine cycle. A machine cycle is CLKS_PER_CYCLE clock cycles (default 12). The count does not change between machine-cycle strobes.
- R3: Counting is allowed only while run_en = 1. When gate_en = 1, gate_pin must also be 1. Otherwise the count holds its value.
- R4: With mode_sel = 0 the value is 13 bits wide: count_hi forms bits 12..5 and count_lo[4:0] forms bits 4..0, while count_lo[7:5] keep their value. Starting from 8192 - N, the value wraps to 0 and overflows on the N-th step.
- R5: With mode_sel = 1 the value {count_hi, count_lo} is 16 bits wide. It wraps from 0xFFFF to 0x0000 with an overflow and no reload.
- R6: With mode_sel = 2 only count_lo advances. When it steps from 0xFF it is reloaded with count_hi and an overflow occurs. count_hi changes only by a write.
- R7: With mode_sel = 3 the count does not advance.
- R8: Every overflow sets ovf_flag. The flag stays set until an ovf_ack pulse clears it. An overflow in the same cycle as an ack leaves the flag set.
- R9: irq follows ovf_flag while irq_en = 1 and is low while irq_en = 0.
- R10: In counter mode (ext_sel = 1) ext_pin is sampled once per machine cycle. A high sample followed by a low sample adds one to the count at the next machine-cycle strobe. A static pin adds nothing, and internal machine cycles are not counted.
- R11: A pin level shorter than a machine cycle may be missed. A square wave on ext_pin with a period of two machine cycles gives one count per period. A square wave with a period of one machine cycle gives no counts.
- R12: A pulse on load_lo_we or load_hi_we writes load_data into that byte at the next clock edge. Counting is suppressed in a cycle that carries a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run control |
| gate_en | input | 1 | Gate qualification enable |
| gate_pin | input | 1 | External gate level, must be high when gating is on |
| ext_sel | input | 1 | 0 = count machine cycles, 1 = count pin falling edges |
| mode_sel | input | 2 | 0 = 13-bit, 1 = 16-bit, 2 = 8-bit auto-reload, 3 = frozen |
| ext_pin | input | 1 | External event input |
| irq_en | input | 1 | Interrupt request enable |
| load_lo_we | input | 1 | Write strobe for the low byte |
| load_hi_we | input | 1 | Write strobe for the high byte |
| load_data | input | 8 | Write data |
| ovf_ack | input | 1 | Clears the overflow flag |
| count_lo | output | 8 | Low count byte |
| count_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Timer runs are opened and closed on the same clock phase over whole multiples of the machine cycle, so the exact step count is known whatever the divider phase. Preloads just below the wrap point of each width separate 13-bit, 16-bit and reload behaviour. The same kind of preload in the frozen mode shows the count stands still. On the external pin, slow pulses show the basic edge counting. A square wave with a two-machine-cycle period shows the maximum rate. A square wave with a one-machine-cycle period always presents the same sampled level, which shows that activity between samples is not counted.

// File: rtl/mmtc_pkg.sv
package mmtc_pkg;

    parameter int unsigned BYTE_W   = 8;
    parameter int unsigned NARROW_W = 13;

    typedef enum logic [1:0] {
        MODE_13B  = 2'd0,
        MODE_16B  = 2'd1,
        MODE_8RL  = 2'd2,
        MODE_HOLD = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              flag;
    } core_st_t;

    typedef struct packed {
        logic smp;
        logic pend;
    } pin_st_t;

endpackage

// File: rtl/mmtc_tick_gen.sv
module mmtc_tick_gen #(
    parameter int unsigned CLKS_PER_CYCLE = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PW = (CLKS_PER_CYCLE > 1) ? $clog2(CLKS_PER_CYCLE) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_CYCLE - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/mmtc_pin_sampler.sv
module mmtc_pin_sampler
    import mmtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic fall_pend_o
);
    pin_st_t st_d, st_q;

    // One sample per machine cycle; an edge found at one strobe is
    // presented until the next strobe, where the core may consume it.
    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.smp  = pin_i;
            st_d.pend = st_q.smp & ~pin_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_pend_o = st_q.pend;
endmodule

// File: rtl/mmtc_count_core.sv
module mmtc_count_core
    import mmtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              count_ok_i,
    input  logic              ext_sel_i,
    input  cnt_mode_e         mode_i,
    input  logic              fall_pend_i,
    input  logic              load_lo_we_i,
    input  logic              load_hi_we_i,
    input  logic [BYTE_W-1:0] load_data_i,
    input  logic              ack_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              flag_o,
    output logic              step_o,
    output logic              ovf_o
);
    localparam int unsigned WIDE_W = 2 * BYTE_W;
    localparam int unsigned LOW_W  = NARROW_W - BYTE_W;

    core_st_t            st_d, st_q;
    logic [NARROW_W-1:0] v13;
    logic [NARROW_W:0]   n13;
    logic [WIDE_W:0]     n16;
    logic                load_any;

    always_comb begin
        st_d     = st_q;
        ovf_o    = 1'b0;
        v13      = {st_q.hi, st_q.lo[LOW_W-1:0]};
        n13      = {1'b0, v13} + (NARROW_W+1)'(1);
        n16      = {1'b0, st_q.hi, st_q.lo} + (WIDE_W+1)'(1);
        load_any = load_lo_we_i | load_hi_we_i;
        step_o   = tick_i && count_ok_i && !load_any && (mode_i != MODE_HOLD)
                   && (ext_sel_i ? fall_pend_i : 1'b1);

        if (load_lo_we_i) st_d.lo = load_data_i;
        if (load_hi_we_i) st_d.hi = load_data_i;

        if (step_o) begin
            case (mode_i)
                MODE_13B: begin
                    st_d.lo = {st_q.lo[BYTE_W-1:LOW_W], n13[LOW_W-1:0]};
                    st_d.hi = n13[NARROW_W-1:LOW_W];
                    ovf_o   = n13[NARROW_W];
                end
                MODE_16B: begin
                    st_d.lo = n16[BYTE_W-1:0];
                    st_d.hi = n16[WIDE_W-1:BYTE_W];
                    ovf_o   = n16[WIDE_W];
                end
                MODE_8RL: begin
                    if (&st_q.lo) begin
                        st_d.lo = st_q.hi;
                        ovf_o   = 1'b1;
                    end else begin
                        st_d.lo = st_q.lo + BYTE_W'(1);
                    end
                end
                default: ;
            endcase
        end

        if (ovf_o)      st_d.flag = 1'b1;
        else if (ack_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_o   = st_q.lo;
    assign hi_o   = st_q.hi;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/mmtc_channel.sv
module mmtc_channel
    import mmtc_pkg::*;
#(
    parameter int unsigned CLKS_PER_CYCLE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              gate_en,
    input  logic              gate_pin,
    input  logic              ext_sel,
    input  logic [1:0]        mode_sel,
    input  logic              ext_pin,
    input  logic              irq_en,
    input  logic              load_lo_we,
    input  logic              load_hi_we,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              ovf_ack,
    output logic [BYTE_W-1:0] count_lo,
    output logic [BYTE_W-1:0] count_hi,
    output logic              ovf_flag,
    output logic              irq
);
    logic tick_w;
    logic fall_w;
    logic step_w;
    logic ovf_w;
    logic count_ok;

    assign count_ok = run_en & (~gate_en | gate_pin);

    mmtc_tick_gen #(.CLKS_PER_CYCLE(CLKS_PER_CYCLE)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    mmtc_pin_sampler u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_w),
        .pin_i       (ext_pin),
        .fall_pend_o (fall_w)
    );

    mmtc_count_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_w),
        .count_ok_i   (count_ok),
        .ext_sel_i    (ext_sel),
        .mode_i       (cnt_mode_e'(mode_sel)),
        .fall_pend_i  (fall_w),
        .load_lo_we_i (load_lo_we),
        .load_hi_we_i (load_hi_we),
        .load_data_i  (load_data),
        .ack_i        (ovf_ack),
        .lo_o         (count_lo),
        .hi_o         (count_hi),
        .flag_o       (ovf_flag),
        .step_o       (step_w),
        .ovf_o        (ovf_w)
    );

    assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/mmtc_channel_chk.sv
module mmtc_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic [1:0] mode_sel,
    input logic       load_lo_we,
    input logic       load_hi_we,
    input logic       ovf_ack,
    input logic [7:0] count_lo,
    input logic [7:0] count_hi,
    input logic       ovf_flag,
    input logic       tick,
    input logic       step,
    input logic       ovf_pulse
);
    assert_no_tick_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_lo_we && !load_hi_we) |=> $stable({count_hi, count_lo}));

    assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_lo_we && !load_hi_we) |=> $stable({count_hi, count_lo}));

    assert_reload_high_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && !load_hi_we) |=> $stable(count_hi));

    assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && step && count_lo == 8'hFF) |=> (count_lo == $past(count_hi)));

    assert_frozen_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd3 && !load_lo_we && !load_hi_we) |=> $stable({count_hi, count_lo}));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> ovf_flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_ack) |=> ovf_flag);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && !ovf_pulse) |=> !ovf_flag);
endmodule

bind mmtc_channel mmtc_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .mode_sel   (mode_sel),
    .load_lo_we (load_lo_we),
    .load_hi_we (load_hi_we),
    .ovf_ack    (ovf_ack),
    .count_lo   (count_lo),
    .count_hi   (count_hi),
    .ovf_flag   (ovf_flag),
    .tick       (tick_w),
    .step       (step_w),
    .ovf_pulse  (ovf_w)
);

// File: tb/mmtc_channel_bench.sv
`timescale 1ns/1ps
module mmtc_channel_bench;
    localparam int CPC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, gate_en = 1'b0, gate_pin = 1'b0, ext_sel = 1'b0;
    logic [1:0] mode_sel = 2'd1;
    logic       ext_pin = 1'b0, irq_en = 1'b0;
    logic       load_lo_we = 1'b0, load_hi_we = 1'b0, ovf_ack = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic [7:0] count_lo, count_hi;
    logic       ovf_flag, irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmtc_channel #(.CLKS_PER_CYCLE(CPC)) u_mmtc_channel (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en),
        .gate_pin(gate_pin), .ext_sel(ext_sel), .mode_sel(mode_sel),
        .ext_pin(ext_pin), .irq_en(irq_en), .load_lo_we(load_lo_we),
        .load_hi_we(load_hi_we), .load_data(load_data), .ovf_ack(ovf_ack),
        .count_lo(count_lo), .count_hi(count_hi), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load(input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk); load_hi_we = 1'b1; load_data = hi;
        @(negedge clk); load_hi_we = 1'b0; load_lo_we = 1'b1; load_data = lo;
        @(negedge clk); load_lo_we = 1'b0;
    endtask

    task automatic run_cycles(input int k);
        @(negedge clk); run_en = 1'b1;
        repeat (CPC * k) @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic ack;
        @(negedge clk); ovf_ack = 1'b1;
        @(negedge clk); ovf_ack = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 count", {count_hi, count_lo}, 16'h0000);
        check("R1 flag/irq", {14'd0, ovf_flag, irq}, 16'h0000);
    endtask

    task automatic t_wide;
        mode_sel = 2'd1; ext_sel = 1'b0; irq_en = 1'b1;
        load(8'hFF, 8'hFD);
        check("R12 load", {count_hi, count_lo}, 16'hFFFD);
        run_cycles(2);
        check("R2 timer steps", {count_hi, count_lo}, 16'hFFFF);
        check("R8 no flag yet", {15'd0, ovf_flag}, 16'h0000);
        run_cycles(1);
        check("R5 wrap", {count_hi, count_lo}, 16'h0000);
        check("R8 flag set", {15'd0, ovf_flag}, 16'h0001);
        check("R9 irq follows", {15'd0, irq}, 16'h0001);
        irq_en = 1'b0; @(negedge clk);
        check("R9 irq masked", {15'd0, irq}, 16'h0000);
        run_cycles(2);
        check("R8 flag stays", {15'd0, ovf_flag}, 16'h0001);
        ack;
        check("R8 ack clears", {15'd0, ovf_flag}, 16'h0000);
    endtask

    task automatic t_narrow;
        mode_sel = 2'd0;
        load(8'hFF, 8'hFB);
        run_cycles(4);
        check("R4 before wrap", {count_hi, count_lo}, 16'hFFFF);
        check("R4 no flag", {15'd0, ovf_flag}, 16'h0000);
        run_cycles(1);
        check("R4 wrap keeps lo[7:5]", {count_hi, count_lo}, 16'h00E0);
        check("R4 flag", {15'd0, ovf_flag}, 16'h0001);
        ack;
    endtask

    task automatic t_reload;
        mode_sel = 2'd2;
        load(8'hF0, 8'hFE);
        run_cycles(1);
        check("R6 step", {count_hi, count_lo}, 16'hF0FF);
        run_cycles(1);
        check("R6 reload", {count_hi, count_lo}, 16'hF0F0);
        check("R6 flag", {15'd0, ovf_flag}, 16'h0001);
        run_cycles(3);
        check("R6 continue", {count_hi, count_lo}, 16'hF0F3);
        ack;
    endtask

    task automatic t_hold_and_gate;
        mode_sel = 2'd1;
        load(8'h12, 8'h30);
        repeat (CPC * 5) @(negedge clk);
        check("R3 run off holds", {count_hi, count_lo}, 16'h1230);
        gate_en = 1'b1; gate_pin = 1'b0;
        run_cycles(4);
        check("R3 gate low holds", {count_hi, count_lo}, 16'h1230);
        gate_pin = 1'b1;
        run_cycles(4);
        check("R3 gate high counts", {count_hi, count_lo}, 16'h1234);
        gate_en = 1'b0; gate_pin = 1'b0;
        mode_sel = 2'd3;
        run_cycles(6);
        check("R7 frozen", {count_hi, count_lo}, 16'h1234);
        mode_sel = 2'd1;
    endtask

    task automatic t_counter;
        logic [15:0] base;
        mode_sel = 2'd1; ext_sel = 1'b1; ext_pin = 1'b0;
        load(8'h00, 8'h00);
        @(negedge clk); run_en = 1'b1;
        repeat (CPC * 6) @(negedge clk);
        check("R10 static pin", {count_hi, count_lo}, 16'h0000);
        for (int i = 0; i < 3; i++) begin
            ext_pin = 1'b1; repeat (2 * CPC) @(negedge clk);
            ext_pin = 1'b0; repeat (2 * CPC) @(negedge clk);
        end
        repeat (3 * CPC) @(negedge clk);
        check("R10 slow edges", {count_hi, count_lo}, 16'h0003);
        for (int i = 0; i < 8; i++) begin
            ext_pin = 1'b1; repeat (CPC) @(negedge clk);
            ext_pin = 1'b0; repeat (CPC) @(negedge clk);
        end
        repeat (3 * CPC) @(negedge clk);
        check("R11 max rate", {count_hi, count_lo}, 16'h000B);
        base = {count_hi, count_lo};
        for (int i = 0; i < 16; i++) begin
            ext_pin = 1'b1; repeat (CPC / 2) @(negedge clk);
            ext_pin = 1'b0; repeat (CPC / 2) @(negedge clk);
        end
        check("R11 too fast ignored", {count_hi, count_lo}, base);
        run_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ext_pin = 1'b1; repeat (CPC / 2) @(negedge clk);
            ext_pin = 1'b0; repeat (CPC / 2) @(negedge clk);
        end
        repeat (3 * CPC) @(negedge clk);
        ext_sel = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_wide;
        t_narrow;
        t_reload;
        t_hold_and_gate;
        t_counter;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule